// File: doc/BRIEF.md
# Multi-Lane Round-Robin Output Queue

This block is the output buffer of one port of a switch whose outputs are served by a group of parallel channels. In every cycle up to `LANES` packets may arrive on parallel input lanes. They leave on a single link at one packet per cycle, using a valid/ready handshake. No single memory is written `LANES` times per cycle. Instead, the packets are spread over `LANES` narrow banks, and each bank takes at most one write and one read per cycle.

A shifting concentrator packs the valid lanes together, keeping their lane order. It then rotates them by a write pointer, so consecutive packets fill consecutive banks in a circular sweep. A read pointer visits the banks in the same circular order, one bank per departure. As a result, the banks behave as one first-in-first-out queue. When the banks are close to full, the arrivals that do not fit are discarded, and the number discarded is reported on a port.

`LANES` must be a power of two, and `DEPTH` must be a power of two. The reference build is 4 lanes, 16 entries per bank and 32-bit packets.

Top module: `grp_rr_out_queue`

## Requirements
- R1: While reset is applied and in the first cycle after it, `out_valid` is 0 and `drop_cnt` is 0.
- R2: When the free space is at least the number of valid lanes, every valid arrival of the cycle is stored and `drop_cnt` reads 0 in the next cycle. This holds for all `LANES` lanes valid at once.
- R3: Packets depart in arrival order. Packets that arrive in the same cycle depart in ascending lane index, with lane 0 first. Lane i carries its packet on `in_data[i*DATA_W +: DATA_W]`.
- R4: Any subset of lanes, contiguous or not, is stored without gaps or duplicates, and the departure order is not disturbed.
- R5: With `out_ready` held at 1, a backlog of stored packets departs at one packet per cycle, with no idle cycle between packets.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change.
- R7: The queue holds `LANES*DEPTH` packets in its banks plus one packet in the output register. Free space is judged from the occupancy at the start of the cycle. When the arrivals exceed the free space, the excess is discarded from the highest lane downward. The number discarded in a cycle appears on `drop_cnt` in the following cycle.
- R8: When the queue is empty and `out_ready` is 1, a packet presented before rising edge k is written at edge k and appears on `out_valid`/`out_data` after edge k+1. With no packet stored, `out_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | LANES | Valid bit of each arrival lane |
| in_data | input | LANES*DATA_W | Packet words of the lanes; lane i at bits i*DATA_W upward |
| out_valid | output | 1 | A packet is presented on the link side |
| out_ready | input | 1 | The link takes the presented packet on this edge |
| out_data | output | DATA_W | Packet presented to the link |
| drop_cnt | output | $clog2(LANES+1) | Arrivals discarded in the previous cycle |

## Verification
The hardest case to reach is the overflow edge. In that cycle the space left is smaller than a full burst, so the concentrator must keep only the lowest lanes while the pointers wrap. The bench stalls the link and sends full four-lane bursts until exactly one slot remains. It then sends a final burst that must leave three lanes discarded, followed by one more arrival into a completely full queue. Afterwards it drains the queue and checks that the departures are exactly the first 65 packets in their original order.

// File: rtl/grp_q_pkg.sv
package grp_q_pkg;

  // Number of set bits among the lowest n bits of v.
  function automatic int count_set(input logic [63:0] v, input int n);
    int c;
    c = 0;
    for (int i = 0; i < n; i++) begin
      if (v[i]) c++;
    end
    return c;
  endfunction

  // Width of a pointer that addresses n banks (minimum 1).
  function automatic int ptr_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/grp_q_bank.sv
module grp_q_bank #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic              full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [AW:0]       cnt;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (wr_en) wr_ptr <= wr_ptr + AW'(1);
      if (rd_en) rd_ptr <= rd_ptr + AW'(1);
      case ({wr_en, rd_en})
        2'b10:   cnt <= cnt + (AW+1)'(1);
        2'b01:   cnt <= cnt - (AW+1)'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign rd_data = mem[rd_ptr];
  assign empty   = (cnt == '0);
  assign full    = (cnt == (AW+1)'(DEPTH));

  AST_BANK_WR_ROOM: assert property (@(posedge clk) disable iff (rst) wr_en |-> !full); // R7
  AST_BANK_RD_HELD: assert property (@(posedge clk) disable iff (rst) rd_en |-> !empty); // R3

endmodule

// File: rtl/grp_q_shift_conc.sv
module grp_q_shift_conc #(
  parameter int LANES  = 4,
  parameter int DATA_W = 32,
  parameter int PW     = 2,
  parameter int CW     = 3
) (
  input  logic [LANES-1:0]        lane_vld,
  input  logic [LANES*DATA_W-1:0] lane_data,
  input  logic [PW-1:0]           wr_ptr,
  input  logic [CW-1:0]           accept_n,
  output logic [LANES-1:0]        bank_we,
  output logic [LANES*DATA_W-1:0] bank_wdata
);
  // Pack valid lanes in ascending order, keep the first accept_n of them,
  // then rotate the packed list so that rank 0 lands in bank wr_ptr.
  always_comb begin
    int rank;
    logic [PW-1:0] tgt;
    bank_we    = '0;
    bank_wdata = '0;
    rank       = 0;
    tgt        = '0;
    for (int i = 0; i < LANES; i++) begin
      if (lane_vld[i]) begin
        if (rank < int'(accept_n)) begin
          tgt = PW'((int'(wr_ptr) + rank) % LANES);
          bank_we[tgt] = 1'b1;
          bank_wdata[int'(tgt)*DATA_W +: DATA_W] = lane_data[i*DATA_W +: DATA_W];
        end
        rank++;
      end
    end
  end

endmodule

// File: rtl/grp_rr_out_queue.sv
module grp_rr_out_queue
  import grp_q_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  localparam int CW    = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES-1:0]        in_vld,
  input  logic [LANES*DATA_W-1:0] in_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [DATA_W-1:0]       out_data,
  output logic [CW-1:0]           drop_cnt
);
  localparam int PW  = ptr_width(LANES);
  localparam int CAP = LANES * DEPTH;
  localparam int OW  = $clog2(CAP + 1);

  logic [PW-1:0]           wp, rp;
  logic [OW-1:0]           occ;
  logic [CW-1:0]           n_valid, n_acc;
  logic                    pop;
  logic [LANES-1:0]        bank_we, bank_re, bank_empty, bank_full;
  logic [LANES*DATA_W-1:0] bank_wdata;
  logic [DATA_W-1:0]       bank_rd [LANES];
  logic [DATA_W-1:0]       head;
  int                      free_i;

  // Arrival accounting against the start-of-cycle occupancy.
  always_comb begin
    n_valid = CW'(count_set(64'(in_vld), LANES));
    free_i  = CAP - int'(occ);
    n_acc   = (int'(n_valid) > free_i) ? CW'(free_i) : n_valid;
  end

  assign pop  = (occ != '0) && (!out_valid || out_ready);
  assign head = bank_rd[rp];

  grp_q_shift_conc #(
    .LANES(LANES), .DATA_W(DATA_W), .PW(PW), .CW(CW)
  ) u_conc (
    .lane_vld  (in_vld),
    .lane_data (in_data),
    .wr_ptr    (wp),
    .accept_n  (n_acc),
    .bank_we   (bank_we),
    .bank_wdata(bank_wdata)
  );

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    assign bank_re[b] = pop && (rp == PW'(b));
    grp_q_bank #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_bank (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (bank_we[b]),
      .wr_data(bank_wdata[b*DATA_W +: DATA_W]),
      .rd_en  (bank_re[b]),
      .rd_data(bank_rd[b]),
      .empty  (bank_empty[b]),
      .full   (bank_full[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp        <= '0;
      rp        <= '0;
      occ       <= '0;
      drop_cnt  <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      wp       <= PW'((int'(wp) + int'(n_acc)) % LANES);
      occ      <= OW'(int'(occ) + int'(n_acc) - (pop ? 1 : 0));
      drop_cnt <= n_valid - n_acc;
      if (pop) begin
        rp        <= PW'((int'(rp) + 1) % LANES);
        out_valid <= 1'b1;
        out_data  <= head;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R6
  AST_NO_DROP_WITH_ROOM: assert property (@(posedge clk) disable iff (rst)
    (int'(n_valid) <= free_i) |=> (drop_cnt == '0)); // R2
  AST_WR_COUNT: assert property (@(posedge clk) disable iff (rst)
    ($countones(bank_we) == int'(n_acc))); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (occ == '0 && !out_valid) |=> !out_valid); // R8
  AST_FULL_BANKS: assert property (@(posedge clk) disable iff (rst)
    (int'(occ) == CAP) |-> (bank_full == '1)); // R7
  AST_EMPTY_BANKS: assert property (@(posedge clk) disable iff (rst)
    (occ == '0) |-> (bank_empty == '1)); // R3

endmodule

// File: tb/test_grp_rr_out_queue.sv
module test_grp_rr_out_queue;
  localparam int LANES = 4;
  localparam int DEPTH = 16;
  localparam int DW    = 32;
  localparam int CW    = $clog2(LANES + 1);

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic [LANES-1:0]      in_vld = '0;
  logic [LANES*DW-1:0]   in_data = '0;
  logic                  out_valid;
  logic                  out_ready = 1'b1;
  logic [DW-1:0]         out_data;
  logic [CW-1:0]         drop_cnt;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [DW-1:0] exp_q [1024];
  logic [DW-1:0] got_q [1024];
  int exp_n = 0, got_n = 0, vbase = 0, serial = 0;
  int ovf_sum = 0, cur_run = 0, last_run = 0;

  always #2 clk = ~clk;

  grp_rr_out_queue #(.LANES(LANES), .DEPTH(DEPTH), .DATA_W(DW)) i_grp_rr_out_queue (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .drop_cnt(drop_cnt)
  );

  // Monitor: record every handshake, drop counts and handshake run lengths.
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      got_q[got_n] = out_data;
      got_n++;
      cur_run++;
    end else begin
      if (cur_run > 0) last_run = cur_run;
      cur_run = 0;
    end
    if (!rst) ovf_sum += int'(drop_cnt);
  end

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  // One cycle of arrivals on the lanes selected by m.
  task automatic cyc(input logic [LANES-1:0] m);
    @(posedge clk); #1;
    in_vld = m;
    for (int l = 0; l < LANES; l++) begin
      if (m[l]) begin
        in_data[l*DW +: DW] = 32'hC0DE_0000 + DW'(serial);
        exp_q[exp_n] = 32'hC0DE_0000 + DW'(serial);
        exp_n++;
        serial++;
      end else begin
        in_data[l*DW +: DW] = '0;
      end
    end
  endtask

  task automatic set_ready(input logic r);
    @(posedge clk); #1;
    out_ready = r;
  endtask

  task automatic verify(input string req, input int limit);
    for (int c = 0; c < limit && got_n < exp_n; c++) @(negedge clk);
    check(got_n == exp_n, req, DW'(got_n), DW'(exp_n));
    for (int i = vbase; i < exp_n && i < got_n; i++)
      check(got_q[i] == exp_q[i], req, got_q[i], exp_q[i]);
    vbase = exp_n;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(out_valid == 1'b0, "R1 valid in reset", DW'(out_valid), 0);
    check(drop_cnt == '0, "R1 drop in reset", DW'(drop_cnt), 0);
    @(posedge clk); #1; rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 valid after reset", DW'(out_valid), 0);
    check(drop_cnt == '0, "R1 drop after reset", DW'(drop_cnt), 0);
  endtask

  task automatic t_latency();
    logic [DW-1:0] first;
    first = 32'hC0DE_0000 + DW'(serial);
    cyc(4'b0100);
    cyc(4'b0000);
    @(negedge clk);
    check(out_valid == 1'b0, "R8 not yet visible", DW'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R8 visible after two edges", DW'(out_valid), 1);
    check(out_data == first, "R8 data", out_data, first);
    verify("R8 order", 20);
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R8 empty stays idle", DW'(out_valid), 0);
  endtask

  task automatic t_burst();
    for (int k = 0; k < 5; k++) cyc(4'b1111);
    cyc(4'b0000);
    verify("R2 R3 full bursts", 60);
    repeat (3) @(negedge clk);
    check(last_run == 20, "R5 back-to-back drain", DW'(last_run), 20);
  endtask

  task automatic t_sparse();
    cyc(4'b1010); cyc(4'b0001); cyc(4'b0110); cyc(4'b0000);
    cyc(4'b1111); cyc(4'b0100); cyc(4'b1001); cyc(4'b0000);
    verify("R4 R3 sparse lanes", 60);
  endtask

  task automatic t_stall();
    logic [DW-1:0] first;
    first = 32'hC0DE_0000 + DW'(serial);
    set_ready(1'b0);
    cyc(4'b0011); cyc(4'b0100); cyc(4'b0000);
    @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(out_valid == 1'b1, "R6 valid held", DW'(out_valid), 1);
      check(out_data == first, "R6 data held", out_data, first);
    end
    set_ready(1'b1);
    verify("R6 R3 after stall", 40);
  endtask

  task automatic t_overflow();
    int o0;
    o0 = ovf_sum;
    set_ready(1'b0);
    for (int k = 0; k < 17; k++) cyc(4'b1111);
    cyc(4'b0000);
    repeat (3) @(negedge clk);
    check(ovf_sum - o0 == 3, "R7 drops at capacity edge", DW'(ovf_sum - o0), 3);
    exp_n -= 3;
    serial -= 0;
    cyc(4'b0001);
    cyc(4'b0000);
    repeat (2) @(negedge clk);
    check(ovf_sum - o0 == 4, "R7 drop when full", DW'(ovf_sum - o0), 4);
    exp_n -= 1;
    check(out_valid == 1'b1, "R7 full queue presents head", DW'(out_valid), 1);
    set_ready(1'b1);
    verify("R7 R3 drain after overflow", 200);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_burst();
    t_sparse();
    t_stall();
    t_overflow();
    t_burst();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule